// File: doc/BRIEF.md
# Command-Word Register Access Bridge

This block puts a single 64-bit command word in front of the small bank of 8-bit registers inside a serial bus controller. The host stores a word in which it has set the top bit. The bridge treats that bit as a busy flag. After a fixed number of clock cycles it carries out the request in the word. If the word asks for a register access, the bridge reads or writes one internal register. It then drops the busy flag. The host polls the word until the flag reads zero. For a read, it then takes the result from the low byte.

The internal bank holds these registers:
- own bus address
- data byte
- control
- clock divider setting
- status, which is read-only and reads as 0xF8 when no bus event has happened
- extended own address

One sub-address is a write-only reset strobe. The bus engine is outside this block. Here it is represented only by these register targets.

Top module: `cmdword_bridge`

## Requirements
- R1: After reset the command word reads as all zeros. A register read of sub-address 3 returns status 0xF8.
- R2: The host stores a word with bit 63 set while bit 63 of the held word is clear. Bit 63 then reads as 1 for exactly `DONE_LAT` cycles after the storing edge, then drops to 0.
- R3: While bit 63 of the held word is set, a host write is ignored. The pending command and its result are not changed.
- R4: Op code 6 (bits [60:57]) with the read flag (bit 56) set returns the register selected by bits [34:32] in bits [7:0]. Bits [62:8] of the word are kept as written.
- R5: Op code 6 with the read flag clear writes bits [7:0] into the register selected by bits [34:32]. Sub-address 0 is the own address, 1 is data, 2 is control and 4 is the extended own address.
- R6: Sub-address 3 selects the clock divider setting on a write and the status byte on a read. Writing it does not change what a status read returns.
- R7: A write to sub-address 7 returns data and control to 0x00 and status to 0xF8. It leaves the own address and the extended own address unchanged.
- R8: Any op code other than 6 finishes after the same latency. It makes no register access and changes only bit 63 of the word.
- R9: A word stored with bit 63 clear is held and reads back at once. It starts no access.
- R10: Reads of sub-addresses 5, 6 and 7 return 0x00. Writes to 5 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Store `host_wdata` into the command word |
| host_wdata | input | 64 | Command word from the host |
| host_rdata | output | 64 | Current command word, including the busy flag and read result |

## Verification
A wrong busy counter shows at the port as a busy flag that drops one cycle early or late. It could also drop never, or the block could accept a second command in the middle of a first one. Either shows within `DONE_LAT` cycles of the command. A corrupt register bank stays hidden until the next read of that sub-address. For that reason the reference model compares the whole word on every cycle. The stimulus also reads back each register after every kind of write, including the reset strobe and the clock-setting write that shares sub-address 3 with status.

// File: rtl/cmdword_pkg.sv
package cmdword_pkg;
  localparam int WORD_W  = 64;
  localparam int REG_W   = 8;
  localparam int SUB_W   = 3;
  localparam int NUM_SUB = 1 << SUB_W;

  localparam int BIT_BUSY = 63;
  localparam int BIT_RDF  = 56;
  localparam int OP_LO    = 57;
  localparam int OP_HI    = 60;
  localparam int SUB_LO   = 32;

  localparam logic [3:0] OP_REGACC = 4'd6;

  typedef enum logic [SUB_W-1:0] {
    SUB_OWNADDR = 3'd0,
    SUB_DATA    = 3'd1,
    SUB_CTRL    = 3'd2,
    SUB_CLKSTAT = 3'd3,
    SUB_EXTADDR = 3'd4,
    SUB_SRST    = 3'd7
  } sub_e;

  localparam logic [REG_W-1:0] STAT_IDLE = 8'hF8;
endpackage

// File: rtl/cmdword_hold.sv
module cmdword_hold
  import cmdword_pkg::*;
#(
  parameter int DONE_LAT = 4,
  localparam int CW = $clog2(DONE_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic [REG_W-1:0]  bank_rdata,
  output logic [WORD_W-1:0] word_q,
  output logic              acc_en,
  output logic              acc_wr,
  output logic [SUB_W-1:0]  acc_sub,
  output logic [REG_W-1:0]  acc_wdata
);
  logic [CW-1:0] cnt_q;
  logic          finish;
  logic          is_regacc;

  assign finish    = (cnt_q == CW'(1));
  assign is_regacc = (word_q[OP_HI:OP_LO] == OP_REGACC);
  assign acc_en    = finish && is_regacc;
  assign acc_wr    = acc_en && !word_q[BIT_RDF];
  assign acc_sub   = word_q[SUB_LO +: SUB_W];
  assign acc_wdata = word_q[REG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
      if (finish) begin
        word_q[BIT_BUSY] <= 1'b0;
        if (is_regacc && word_q[BIT_RDF])
          word_q[REG_W-1:0] <= bank_rdata;
      end
    end else if (host_wr) begin
      word_q <= host_wdata;
      if (host_wdata[BIT_BUSY])
        cnt_q <= CW'(DONE_LAT);
    end
  end

  // R2
  busy_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> word_q[BIT_BUSY]);

  // R2
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(word_q[BIT_BUSY]) |-> ($past(cnt_q) == CW'(1)));

  // R3
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q > CW'(1) && host_wr) |=> $stable(word_q));
endmodule

// File: rtl/cmdword_bank.sv
module cmdword_bank
  import cmdword_pkg::*;
#(
  parameter logic [NUM_SUB-1:0] WR_MASK   = 8'b0001_1111,
  parameter logic [NUM_SUB-1:0] SRST_MASK = 8'b0000_0110
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SUB_W-1:0] waddr,
  input  logic [REG_W-1:0] wdata,
  input  logic [SUB_W-1:0] raddr,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] slot [NUM_SUB];
  logic [REG_W-1:0] stat_q;
  logic             srst;

  assign srst = wr_en && (waddr == SUB_SRST);

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_slot
    if (WR_MASK[i]) begin : g_rw
      always_ff @(posedge clk) begin
        if (rst)
          slot[i] <= '0;
        else if (srst && SRST_MASK[i])
          slot[i] <= '0;
        else if (wr_en && waddr == SUB_W'(i))
          slot[i] <= wdata;
      end
    end else begin : g_none
      assign slot[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || srst)
      stat_q <= STAT_IDLE;
  end

  always_comb begin
    if (raddr == SUB_CLKSTAT)
      rdata = stat_q;
    else if (WR_MASK[raddr])
      rdata = slot[raddr];
    else
      rdata = '0;
  end

  // R5
  data_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && waddr == SUB_DATA) |=> (slot[SUB_DATA] == $past(wdata)));

  // R7
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    srst |=> (slot[SUB_CTRL] == '0 && slot[SUB_DATA] == '0 && stat_q == STAT_IDLE));

  // R7
  keep_addr_chk: assert property (@(posedge clk) disable iff (rst)
    srst |=> $stable(slot[SUB_OWNADDR]));
endmodule

// File: rtl/cmdword_bridge.sv
module cmdword_bridge
  import cmdword_pkg::*;
#(
  parameter int DONE_LAT = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic [63:0] host_wdata,
  output logic [63:0] host_rdata
);
  logic              acc_en;
  logic              acc_wr;
  logic [SUB_W-1:0]  acc_sub;
  logic [REG_W-1:0]  acc_wdata;
  logic [REG_W-1:0]  bank_rdata;

  cmdword_hold #(.DONE_LAT(DONE_LAT)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .bank_rdata (bank_rdata),
    .word_q     (host_rdata),
    .acc_en     (acc_en),
    .acc_wr     (acc_wr),
    .acc_sub    (acc_sub),
    .acc_wdata  (acc_wdata)
  );

  cmdword_bank u_bank (
    .clk   (clk),
    .rst   (rst),
    .wr_en (acc_wr),
    .waddr (acc_sub),
    .wdata (acc_wdata),
    .raddr (acc_sub),
    .rdata (bank_rdata)
  );

  // R4
  rd_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && host_rdata[BIT_RDF]) |-> !acc_wr);
endmodule

// File: tb/sim_cmdword_bridge.sv
module sim_cmdword_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;

  logic        clk = 0;
  logic        rst = 1;
  logic        host_wr = 0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  cmdword_bridge #(.DONE_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [63:0] m_word;
  int          m_cnt;
  logic [7:0]  m_reg [8];
  logic [7:0]  m_stat;

  function automatic logic [7:0] m_read(input int s);
    if (s == 3) return m_stat;
    if (s == 0 || s == 1 || s == 2 || s == 4) return m_reg[s];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_word = '0; m_cnt = 0; m_stat = 8'hF8;
      for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
    end else if (m_cnt > 0) begin
      if (m_cnt == 1) begin
        if (m_word[60:57] == 4'd6) begin
          int s;
          s = int'(m_word[34:32]);
          if (m_word[56]) m_word[7:0] = m_read(s);
          else if (s == 7) begin m_reg[1] = 0; m_reg[2] = 0; m_stat = 8'hF8; end
          else if (s != 3 && s < 5) m_reg[s] = m_word[7:0];
        end
        m_word[63] = 1'b0;
      end
      m_cnt--;
    end else if (host_wr) begin
      m_word = host_wdata;
      if (host_wdata[63]) m_cnt = LAT;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      vectors++;
      if (host_rdata !== m_word) begin
        errors++;
        $display("FAIL %s: word %h expected %h", cur_req, host_rdata, m_word);
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, got %0d expected <20000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic logic [63:0] mk(input logic v, input logic [3:0] op,
      input logic rd, input logic [2:0] sub, input logic [7:0] d);
    return {v, 2'b00, op, rd, 21'h0A5A5, sub, 24'h000000, d};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [63:0] w, output int n);
    @(negedge clk); host_wr = 1; host_wdata = w;
    @(negedge clk); host_wr = 0;
    n = 0;
    while (host_rdata[63] && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic rd_reg(input string req, input logic [2:0] s, input logic [7:0] exp);
    int n;
    issue(mk(1, 4'd6, 1, s, 8'h33), n);
    check(req, host_rdata, mk(0, 4'd6, 1, s, exp));
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
    int n;
    issue(mk(1, 4'd6, 0, s, d), n);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    check("R1", host_rdata, 64'h0);
    rd_reg("R1", 3, 8'hF8);

    cur_req = "R2";
    issue(mk(1, 4'd6, 1, 3'd0, 8'h00), n);
    check("R2", 64'(n), 64'(LAT));

    cur_req = "R5";
    wr_reg(0, 8'h5C); wr_reg(1, 8'hA7); wr_reg(2, 8'h41); wr_reg(4, 8'h1E);
    rd_reg("R5", 0, 8'h5C);
    rd_reg("R5", 1, 8'hA7);
    rd_reg("R4", 2, 8'h41);
    rd_reg("R4", 4, 8'h1E);

    cur_req = "R6";
    wr_reg(3, 8'h2B);
    rd_reg("R6", 3, 8'hF8);

    cur_req = "R3";
    @(negedge clk); host_wr = 1; host_wdata = mk(1, 4'd6, 1, 3'd1, 8'h00);
    @(negedge clk); host_wdata = mk(1, 4'd6, 0, 3'd1, 8'hEE);
    @(negedge clk); host_wr = 0;
    repeat (LAT) @(negedge clk);
    check("R3", host_rdata, mk(0, 4'd6, 1, 3'd1, 8'hA7));
    rd_reg("R3", 1, 8'hA7);

    cur_req = "R8";
    issue(mk(1, 4'd2, 0, 3'd1, 8'h99), n);
    check("R8", host_rdata, mk(0, 4'd2, 0, 3'd1, 8'h99));
    check("R8", 64'(n), 64'(LAT));
    rd_reg("R8", 1, 8'hA7);

    cur_req = "R9";
    @(negedge clk); host_wr = 1; host_wdata = mk(0, 4'd6, 0, 3'd1, 8'h11);
    @(negedge clk); host_wr = 0;
    check("R9", host_rdata, mk(0, 4'd6, 0, 3'd1, 8'h11));
    rd_reg("R9", 1, 8'hA7);

    cur_req = "R10";
    wr_reg(5, 8'h77); wr_reg(6, 8'h66);
    rd_reg("R10", 5, 8'h00);
    rd_reg("R10", 6, 8'h00);
    rd_reg("R10", 7, 8'h00);

    cur_req = "R7";
    wr_reg(7, 8'h00);
    rd_reg("R7", 1, 8'h00);
    rd_reg("R7", 2, 8'h00);
    rd_reg("R7", 3, 8'hF8);
    rd_reg("R7", 0, 8'h5C);
    rd_reg("R7", 4, 8'h1E);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule